// File: doc/BRIEF.md
# Prioritised interrupt controller with non-maskable input

This block sits between the interrupt lines of a small 8-bit core and the core's sequencer. It watches one non-maskable input and a set of maskable sources. Two of the maskable sources are external active-low pins, and their sensitivity can be configured. The remaining maskable sources are active-high pulses from on-chip peripherals. Each event is captured in a pending flag. A global enable bit gates the maskable sources. The controller picks one winner and presents a registered request together with a vector number.

The core answers with an acknowledge pulse when it takes the offered vector, and with a return pulse when it leaves a handler. The controller uses these two pulses to track which handlers are running. A non-maskable handler may interrupt a maskable one. No other nesting is allowed. A separate wake output tells the power controller that a serviceable event is waiting.

Top module: `intc_core`

## Requirements
- R1: After reset the request, vector and wake outputs are 0, the global enable is off, and both external pins are in falling-edge mode.
- R2: A configuration write takes effect only when `cfg_addr` equals 8'hC8. In the written byte, bit 4 is the global enable, bit 6 selects the mode of external pin 1, and bit 5 selects the edge of external pin 2. Bit 7 and bits 3:0 have no effect.
- R3: External pin 1 in edge mode (bit 6 = 0) latches a falling edge. In level mode (bit 6 = 1) it is pending whenever the pin is low, including after it has been acknowledged.
- R4: External pin 2 latches a falling edge when bit 5 = 0 and a rising edge when bit 5 = 1. The other edge is ignored.
- R5: Maskable events that arrive while the global enable is 0 stay latched and are requested once the enable is set.
- R6: Vector numbers are fixed: NMI = 0, external pin 1 = 1, external pin 2 = 2, and peripheral input k = 3+k. Among pending maskable sources, the lowest vector number is offered.
- R7: A pending NMI is requested regardless of the global enable and may preempt a running maskable handler. It is never requested while an NMI handler is running.
- R8: While a maskable handler runs, no maskable source is requested. A return pulse closes the NMI handler first if one is running, and otherwise closes the maskable handler.
- R9: An acknowledge clears the edge flag of the offered vector. The request for that vector drops in the cycle after the acknowledge.
- R10: The wake output is high only when the global enable is set and some source (including the NMI) is pending. A pending NMI with the enable at 0 does not raise wake.
- R11: An event present at a clock edge shows up on the request outputs right after that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| nmi_n | input | 1 | Non-maskable input, falling-edge triggered |
| ext1_n | input | 1 | External pin 1, active low, edge or level |
| ext2_n | input | 1 | External pin 2, selectable edge |
| periph_irq | input | NUM_MASK-2 | Peripheral event inputs, rising-edge triggered |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | ADDR_W | Configuration write address |
| cfg_wdata | input | DATA_W | Configuration write data |
| irq_ack | input | 1 | Core takes the offered vector |
| irq_ret | input | 1 | Core leaves the current handler |
| irq_req | output | 1 | Interrupt request to the core |
| irq_vec | output | VEC_W | Offered vector number |
| wake | output | 1 | Wake indication for low-power states |

## Verification
Several properties are checked on every cycle by the assertions:
- no NMI is offered while an NMI handler runs;
- while any handler runs, only the NMI may be offered;
- maskable requests and wake both imply the global enable;
- the vector stays in range;
- an acknowledged vector is not offered again on the next cycle.

Other behaviours can only be shown by the directed scenarios. These cover:
- which edge or level each pin responds to;
- that events latched while the enable is off are served later;
- the lowest-number-wins order;
- address and reserved-bit decoding of the configuration write;
- the unwinding order of returns after an NMI has preempted a maskable handler.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int unsigned CFG_LVL1_BIT = 6;
  localparam int unsigned CFG_POL2_BIT = 5;
  localparam int unsigned CFG_GEN_BIT  = 4;

  typedef struct packed {
    logic gen;
    logic lvl1;
    logic pol2;
  } intc_cfg_t;
endpackage

// File: rtl/intc_src_latch.sv
module intc_src_latch #(
  parameter bit PREV_INIT = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic line_i,
  input  logic level_i,
  input  logic rise_i,
  input  logic clr_i,
  output logic pend_o
);
  logic prev_q, flag_q, flag_d, evt;

  always_comb begin
    evt = rise_i ? (~prev_q & line_i) : (prev_q & ~line_i);
    if (level_i) flag_d = 1'b0;
    else         flag_d = evt | (flag_q & ~clr_i);
    pend_o = level_i ? ~line_i : flag_d;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= PREV_INIT;
      flag_q <= 1'b0;
    end else begin
      prev_q <= line_i;
      flag_q <= flag_d;
    end
  end
endmodule

// File: rtl/intc_prio_pick.sv
module intc_prio_pick #(
  parameter int N = 4,
  parameter int W = 3
) (
  input  logic [N-1:0] pend_i,
  output logic         any_o,
  output logic [W-1:0] idx_o
);
  always_comb begin
    any_o = |pend_i;
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (pend_i[i]) idx_o = W'(i);
    end
  end
endmodule

// File: rtl/intc_core.sv
module intc_core
  import intc_pkg::*;
#(
  parameter int NUM_MASK = 4,
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 8,
  parameter logic [ADDR_W-1:0] CFG_ADDR = 'hC8,
  localparam int VEC_W   = $clog2(NUM_MASK + 1),
  localparam int NPER    = NUM_MASK - 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              nmi_n,
  input  logic              ext1_n,
  input  logic              ext2_n,
  input  logic [NPER-1:0]   periph_irq,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [DATA_W-1:0] cfg_wdata,
  input  logic              irq_ack,
  input  logic              irq_ret,
  output logic              irq_req,
  output logic [VEC_W-1:0]  irq_vec,
  output logic              wake
);
  intc_cfg_t cfg_q, cfg_d;
  logic nmi_act_q, nmi_act_d, msk_act_q, msk_act_d;
  logic req_q, req_d, wake_q, wake_d;
  logic [VEC_W-1:0] vec_q, vec_d;
  logic [NUM_MASK-1:0] m_line, m_lvl, m_rise, m_clr, m_pend;
  logic nmi_pend, ack_take, ack_nmi, m_any;
  logic [VEC_W-1:0] m_idx;
  logic unused_cfg_bits;

  assign unused_cfg_bits = ^{cfg_wdata[DATA_W-1], cfg_wdata[3:0]};

  // configuration register
  always_comb begin
    cfg_d = cfg_q;
    if (cfg_we && cfg_addr == CFG_ADDR) begin
      cfg_d.gen  = cfg_wdata[CFG_GEN_BIT];
      cfg_d.lvl1 = cfg_wdata[CFG_LVL1_BIT];
      cfg_d.pol2 = cfg_wdata[CFG_POL2_BIT];
    end
  end

  assign ack_take = irq_ack & req_q;
  assign ack_nmi  = ack_take & (vec_q == '0);

  intc_src_latch #(.PREV_INIT(1'b1)) u_nmi (
    .clk(clk), .rst(rst), .line_i(nmi_n), .level_i(1'b0), .rise_i(1'b0),
    .clr_i(ack_nmi), .pend_o(nmi_pend)
  );

  for (genvar i = 0; i < NUM_MASK; i++) begin : g_src
    if (i == 0) begin : g_ext1
      assign m_line[i] = ext1_n;
      assign m_lvl[i]  = cfg_q.lvl1;
      assign m_rise[i] = 1'b0;
    end else if (i == 1) begin : g_ext2
      assign m_line[i] = ext2_n;
      assign m_lvl[i]  = 1'b0;
      assign m_rise[i] = cfg_q.pol2;
    end else begin : g_per
      assign m_line[i] = periph_irq[i-2];
      assign m_lvl[i]  = 1'b0;
      assign m_rise[i] = 1'b1;
    end
    assign m_clr[i] = ack_take & (vec_q == VEC_W'(i + 1));
    intc_src_latch #(.PREV_INIT(i < 2 ? 1'b1 : 1'b0)) u_latch (
      .clk(clk), .rst(rst), .line_i(m_line[i]), .level_i(m_lvl[i]),
      .rise_i(m_rise[i]), .clr_i(m_clr[i]), .pend_o(m_pend[i])
    );
  end

  intc_prio_pick #(.N(NUM_MASK), .W(VEC_W)) u_pick (
    .pend_i(m_pend), .any_o(m_any), .idx_o(m_idx)
  );

  // handler tracking and next request
  always_comb begin
    nmi_act_d = nmi_act_q;
    msk_act_d = msk_act_q;
    if (ack_nmi)                    nmi_act_d = 1'b1;
    else if (irq_ret && nmi_act_q)  nmi_act_d = 1'b0;
    if (ack_take && !ack_nmi)       msk_act_d = 1'b1;
    else if (irq_ret && !nmi_act_q) msk_act_d = 1'b0;

    req_d = 1'b0;
    vec_d = '0;
    if (nmi_pend && !nmi_act_d) begin
      req_d = 1'b1;
    end else if (!nmi_act_d && !msk_act_d && cfg_d.gen && m_any) begin
      req_d = 1'b1;
      vec_d = m_idx + VEC_W'(1);
    end
    wake_d = cfg_d.gen & (nmi_pend | m_any);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q     <= '0;
      nmi_act_q <= 1'b0;
      msk_act_q <= 1'b0;
      req_q     <= 1'b0;
      vec_q     <= '0;
      wake_q    <= 1'b0;
    end else begin
      cfg_q     <= cfg_d;
      nmi_act_q <= nmi_act_d;
      msk_act_q <= msk_act_d;
      req_q     <= req_d;
      vec_q     <= vec_d;
      wake_q    <= wake_d;
    end
  end

  assign irq_req = req_q;
  assign irq_vec = vec_q;
  assign wake    = wake_q;

  a_r7_no_nmi_nest: assert property (@(posedge clk) disable iff (rst)
    nmi_act_q |-> !(req_q && vec_q == '0));
  a_r8_no_mask_nest: assert property (@(posedge clk) disable iff (rst)
    ((msk_act_q || nmi_act_q) && req_q) |-> (vec_q == '0));
  a_r5_gen_gate: assert property (@(posedge clk) disable iff (rst)
    (req_q && vec_q != '0) |-> cfg_q.gen);
  a_r10_wake_gen: assert property (@(posedge clk) disable iff (rst)
    wake_q |-> cfg_q.gen);
  a_r6_vec_range: assert property (@(posedge clk) disable iff (rst)
    req_q |-> (vec_q <= VEC_W'(NUM_MASK)));
  a_r9_ack_drop: assert property (@(posedge clk) disable iff (rst)
    (irq_ack && req_q) |=> !(req_q && vec_q == $past(vec_q)));
endmodule

// File: tb/intc_core_test.sv
module intc_core_test;
  localparam int VW = 3;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic nmi_n = 1'b1, ext1_n = 1'b1, ext2_n = 1'b1;
  logic [1:0] periph_irq = '0;
  logic cfg_we = 1'b0;
  logic [7:0] cfg_addr = '0, cfg_wdata = '0;
  logic irq_ack = 1'b0, irq_ret = 1'b0;
  logic irq_req, wake;
  logic [VW-1:0] irq_vec;
  int total = 0, bad = 0;

  always #4 clk = ~clk;

  intc_core uut (
    .clk(clk), .rst(rst), .nmi_n(nmi_n), .ext1_n(ext1_n), .ext2_n(ext2_n),
    .periph_irq(periph_irq), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .irq_ack(irq_ack), .irq_ret(irq_ret),
    .irq_req(irq_req), .irq_vec(irq_vec), .wake(wake)
  );

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // request check: 0 = no request, otherwise vector+1
  task automatic chk_req(string tag, int exp);
    chk(tag, irq_req ? int'(irq_vec) + 1 : 0, exp);
  endtask

  task automatic cfg(logic [7:0] a, logic [7:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    step();
    cfg_we = 1'b0;
  endtask

  task automatic ack();
    irq_ack = 1'b1; step(); irq_ack = 1'b0;
  endtask

  task automatic ret();
    irq_ret = 1'b1; step(); irq_ret = 1'b0;
  endtask

  task automatic t_reset();
    chk_req("R1 req after reset", 0);
    chk("R1 vec after reset", int'(irq_vec), 0);
    chk("R1 wake after reset", int'(wake), 0);
  endtask

  task automatic t_latch_disabled();
    ext1_n = 1'b0; step();
    chk_req("R5 no request while disabled (R1 enable off)", 0);
    chk("R10 no wake while disabled", int'(wake), 0);
    ext1_n = 1'b1; step();
    cfg(8'hC8, 8'h10);
    chk_req("R5 latched event served after enable", 2);
    chk("R10 wake with enable and pending", int'(wake), 1);
    ack();
    chk_req("R9 request drops after ack", 0);
    chk("R10 wake drops when nothing pending", int'(wake), 0);
    ret();
  endtask

  task automatic t_cfg_decode();
    cfg(8'hC8, 8'h00);
    periph_irq[0] = 1'b1; step(); periph_irq[0] = 1'b0; step();
    cfg(8'hC9, 8'h10);
    chk_req("R2 other address ignored", 0);
    cfg(8'hC8, 8'h80);
    chk_req("R2 bit7 has no effect", 0);
    cfg(8'hC8, 8'h0F);
    chk_req("R2 bits 3:0 have no effect", 0);
    cfg(8'hC8, 8'h90);
    chk_req("R2 enable bit4 takes effect", 4);
    ack(); ret();
  endtask

  task automatic t_priority();
    cfg(8'hC8, 8'h10);
    ext2_n = 1'b0; periph_irq[1] = 1'b1; step();
    chk_req("R6 lower vector wins (R11 same edge)", 3);
    ext2_n = 1'b1; periph_irq[1] = 1'b0;
    ack();
    chk_req("R8 no maskable during maskable handler", 0);
    step();
    chk_req("R8 still held off", 0);
    ret();
    chk_req("R6 next source after return", 5);
    ack();
    ret();
    chk_req("R9 acked edge source not re-requested", 0);
  endtask

  task automatic t_nmi_nesting();
    ext1_n = 1'b0; step(); ext1_n = 1'b1;
    chk_req("R3 falling edge on pin 1", 2);
    ack();
    nmi_n = 1'b0; step(); nmi_n = 1'b1;
    chk_req("R7 NMI preempts maskable handler", 1);
    ack();
    nmi_n = 1'b0; periph_irq[0] = 1'b1; step();
    nmi_n = 1'b1; periph_irq[0] = 1'b0;
    chk_req("R7 no NMI inside NMI handler", 0);
    ret();
    chk_req("R7 pending NMI after NMI return", 1);
    ack();
    ret();
    chk_req("R8 return closed NMI, maskable still running", 0);
    ret();
    chk_req("R8 maskable served after last return", 4);
    ack(); ret();
  endtask

  task automatic t_level();
    cfg(8'hC8, 8'h50);
    ext1_n = 1'b0; step();
    chk_req("R3 level low requested", 2);
    ack();
    chk_req("R3 level acked, handler running", 0);
    ret();
    chk_req("R3 level still low re-requested", 2);
    ack();
    ext1_n = 1'b1;
    ret();
    chk_req("R3 level released not requested", 0);
    cfg(8'hC8, 8'h10);
  endtask

  task automatic t_ext2_rising();
    cfg(8'hC8, 8'h30);
    ext2_n = 1'b0; step();
    chk_req("R4 falling edge ignored in rising mode", 0);
    ext2_n = 1'b1; step();
    chk_req("R4 rising edge latched", 3);
    ack(); ret();
    cfg(8'hC8, 8'h10);
  endtask

  task automatic t_nmi_wake();
    cfg(8'hC8, 8'h00);
    nmi_n = 1'b0; step(); nmi_n = 1'b1;
    chk_req("R7 NMI with enable off", 1);
    chk("R10 NMI does not wake with enable off", int'(wake), 0);
    ack(); ret();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) step();
    rst = 1'b0;
    step();
    t_reset();
    t_latch_disabled();
    t_cfg_decode();
    t_priority();
    t_nmi_nesting();
    t_level();
    t_ext2_rising();
    t_nmi_wake();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule